// File: doc/BRIEF.md
# GPIO Edge Interrupt Unit

This block watches a vector of already-synchronized general-purpose inputs and turns selected transitions into interrupt requests. Each pin has two independent enables, one for low-to-high transitions and one for high-to-low transitions. An enabled transition latches a sticky bit in an event status register. Software clears that bit by writing a one to it.

The pins are split into banks of equal size. Each bank drives one level-sensitive interrupt line. The line stays high while any status bit of that bank is set and the bank's enable bit is on. A host reaches the registers through a simple single-cycle write port and a combinational read port.

Each enable mask has no plain write location. It has one address that sets bits and another that clears bits. Because of this, two agents can change different pins without a read-modify-write sequence.

Top module: `gpio_edge_irq_unit`

## Requirements
- R1: Writing to address 0 sets every low-to-high enable bit whose data bit is 1. Writing to address 1 clears every such bit whose data bit is 1. Zero data bits leave the mask unchanged. Reading address 0 or 1 returns the low-to-high mask.
- R2: Addresses 2 (set) and 3 (clear) act on the high-to-low enable mask in the same way as R1. Reading address 2 or 3 returns that mask.
- R3: A pin whose low-to-high enable is 1 and whose input rises sets its status bit at the first clock edge that samples the new value. The same transition with the enable at 0 sets nothing.
- R4: A pin whose high-to-low enable is 1 and whose input falls sets its status bit at the first clock edge that samples the new value. The same transition with the enable at 0 sets nothing.
- R5: A pin with both enables at 1 sets its status bit on a transition in either direction.
- R6: Writing to address 4 clears each status bit whose data bit is 1 and leaves the other status bits unchanged. Reading address 4 returns the status register. Status bits never clear by themselves.
- R7: When a qualifying transition and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R8: Interrupt line 0 reflects status bits 15:0 and line 1 reflects bits 31:16. A line is high exactly while its bank enable is 1 and at least one status bit of its bank is 1.
- R9: Address 5 holds a 5-bit bank enable register, written directly and readable. Bit b gates line b, and writing all ones enables every line. Bits without a bank are stored and read back.
- R10: Reset clears both enable masks, the status register and the bank enable register, so all reads return 0 and both lines are low.
- R11: Writing all ones to addresses 1 and 3 clears every enable. After that, no pin transition sets any status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pins_i | input | 32 | Synchronized pin levels |
| wr_en_i | input | 1 | Register write strobe, one cycle per write |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 32 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 32 | Read data, combinational from rd_addr_i |
| bank_irq_o | output | 2 | Level interrupt line per bank |

## Verification
Several behaviours are checked by assertions on every cycle:
- set-address writes always leave their data bits set in the mask, and clear-address writes always leave them clear;
- a status bit never falls without a clearing write;
- a status bit rises only because of an enabled transition;
- a transition that coincides with a clear always wins;
- a disabled bank never drives its line.

Other behaviours can only be shown by the bench's directed scenarios:
- the direction selectivity of each enable;
- the bank split of the interrupt lines;
- the read-back of the spare bank enable bits;
- the bulk disable followed by pin activity that leaves the status register at zero.

// File: rtl/gei_pkg.sv
package gei_pkg;

    typedef enum logic [2:0] {
        SEL_RISE_SET = 3'd0,
        SEL_RISE_CLR = 3'd1,
        SEL_FALL_SET = 3'd2,
        SEL_FALL_CLR = 3'd3,
        SEL_STATUS   = 3'd4,
        SEL_BANK_EN  = 3'd5
    } reg_sel_e;

endpackage

// File: rtl/gei_mask_reg.sv
// Enable mask with separate write-one-to-set and write-one-to-clear strobes.
// Instantiated once per edge direction (R1, R2).
module gei_mask_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         set_stb,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);

    logic [W-1:0] set_bits;
    logic [W-1:0] clr_bits;
    logic [W-1:0] mask_d;

    always_comb begin
        set_bits = set_stb ? wdata : '0;
        clr_bits = clr_stb ? wdata : '0;
        mask_d   = (mask_q | set_bits) & ~clr_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else begin
            mask_q <= mask_d;
        end
    end

    AST_MASK_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb && !clr_stb) |=> ((mask_q & $past(wdata)) == $past(wdata))) // R1
        else $error("set strobe did not set mask bits");

    AST_MASK_CLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((mask_q & $past(wdata)) == '0)) // R11
        else $error("clear strobe left mask bits set");

    AST_MASK_UNTOUCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_stb && !clr_stb) |=> $stable(mask_q)) // R2
        else $error("mask changed without a strobe");

endmodule

// File: rtl/gei_edge_status.sv
// Transition detection against the previous sample, with sticky status bits.
module gei_edge_status #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic         clr_stb,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] status_q
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rose;
    logic [W-1:0] fell;
    logic [W-1:0] hits;
    logic [W-1:0] clr_bits;
    logic [W-1:0] status_d;

    always_comb begin
        rose     = pins & ~prev_q;
        fell     = ~pins & prev_q;
        hits     = (rose & rise_en) | (fell & fall_en);
        clr_bits = clr_stb ? wdata : '0;
        // A new event overrides a coincident clear
        status_d = (status_q & ~clr_bits) | hits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q   <= '0;
            status_q <= '0;
        end else begin
            prev_q   <= pins;
            status_q <= status_d;
        end
    end

    AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_stb |=> ((status_q & $past(status_q)) == $past(status_q))) // R6
        else $error("status bit dropped without a clear");

    AST_STATUS_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(hits)) == '0)) // R3
        else $error("status bit rose without an enabled transition");

    AST_EDGE_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && |(hits & wdata)) |=>
            ((status_q & $past(hits & wdata)) == $past(hits & wdata))) // R7
        else $error("coincident clear beat a new event");

endmodule

// File: rtl/gei_bank_gate.sv
// One bank's level interrupt: any pending bit in the slice, gated by enable.
module gei_bank_gate #(
    parameter int N = 16
) (
    input  logic [N-1:0] slice,
    input  logic         enable,
    output logic         irq
);

    always_comb begin
        irq = enable & (|slice);
    end

endmodule

// File: rtl/gpio_edge_irq_unit.sv
module gpio_edge_irq_unit
    import gei_pkg::*;
#(
    parameter int NPINS     = 32,
    parameter int BANK_PINS = 16,
    parameter int BEN_W     = 5,
    parameter int AW        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pins_i,
    input  logic             wr_en_i,
    input  logic [AW-1:0]    wr_addr_i,
    input  logic [NPINS-1:0] wr_data_i,
    input  logic [AW-1:0]    rd_addr_i,
    output logic [NPINS-1:0] rd_data_o,
    output logic [NPINS/BANK_PINS-1:0] bank_irq_o
);

    localparam int NBANKS = NPINS / BANK_PINS;

    logic             rise_set, rise_clr, fall_set, fall_clr, stat_clr, ben_wr;
    logic [NPINS-1:0] rise_mask, fall_mask, status;
    logic [BEN_W-1:0] bank_en_q;

    always_comb begin
        rise_set = wr_en_i && (wr_addr_i == AW'(SEL_RISE_SET));
        rise_clr = wr_en_i && (wr_addr_i == AW'(SEL_RISE_CLR));
        fall_set = wr_en_i && (wr_addr_i == AW'(SEL_FALL_SET));
        fall_clr = wr_en_i && (wr_addr_i == AW'(SEL_FALL_CLR));
        stat_clr = wr_en_i && (wr_addr_i == AW'(SEL_STATUS));
        ben_wr   = wr_en_i && (wr_addr_i == AW'(SEL_BANK_EN));
    end

    gei_mask_reg #(.W(NPINS)) u_rise (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (rise_set),
        .clr_stb (rise_clr),
        .wdata   (wr_data_i),
        .mask_q  (rise_mask)
    );

    gei_mask_reg #(.W(NPINS)) u_fall (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (fall_set),
        .clr_stb (fall_clr),
        .wdata   (wr_data_i),
        .mask_q  (fall_mask)
    );

    gei_edge_status #(.W(NPINS)) u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (pins_i),
        .rise_en  (rise_mask),
        .fall_en  (fall_mask),
        .clr_stb  (stat_clr),
        .wdata    (wr_data_i),
        .status_q (status)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_en_q <= '0;
        end else if (ben_wr) begin
            bank_en_q <= wr_data_i[BEN_W-1:0];
        end
    end

    generate
        for (genvar b = 0; b < NBANKS; b++) begin : g_bank
            gei_bank_gate #(.N(BANK_PINS)) u_gate (
                .slice  (status[b*BANK_PINS +: BANK_PINS]),
                .enable (bank_en_q[b]),
                .irq    (bank_irq_o[b])
            );

            AST_BANK_GATED: assert property (@(posedge clk) disable iff (!rst_n)
                !bank_en_q[b] |-> !bank_irq_o[b]) // R8
                else $error("disabled bank drives its line");
        end
    endgenerate

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            AW'(SEL_RISE_SET), AW'(SEL_RISE_CLR): rd_data_o = rise_mask;
            AW'(SEL_FALL_SET), AW'(SEL_FALL_CLR): rd_data_o = fall_mask;
            AW'(SEL_STATUS):                      rd_data_o = status;
            AW'(SEL_BANK_EN):                     rd_data_o[BEN_W-1:0] = bank_en_q;
            default:                              rd_data_o = '0;
        endcase
    end

    AST_BEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !ben_wr |=> $stable(bank_en_q)) // R9
        else $error("bank enable changed without a write");

endmodule

// File: tb/sim_gpio_edge_irq_unit.sv
module sim_gpio_edge_irq_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] pins;
    logic        wr_en;
    logic [2:0]  wr_addr;
    logic [31:0] wr_data;
    logic [2:0]  rd_addr;
    logic [31:0] rd_data;
    logic [1:0]  bank_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    gpio_edge_irq_unit u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .pins_i     (pins),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .bank_irq_o (bank_irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic drive(input logic [31:0] p);
        @(negedge clk);
        pins = p;
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset_state();
        logic [31:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R10 reg after reset", v, 32'h0);
        end
        chk("R10 irq after reset", {30'h0, bank_irq}, 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(3'd0, 32'h0000_00F0);
        wr(3'd0, 32'h0000_0001);
        rd(3'd0, v); chk("R1 rise set accumulates", v, 32'h0000_00F1);
        wr(3'd1, 32'h0000_0010);
        rd(3'd1, v); chk("R1 rise clear bit", v, 32'h0000_00E1);
        wr(3'd2, 32'hA000_0000);
        wr(3'd3, 32'h2000_0000);
        rd(3'd2, v); chk("R2 fall set/clear", v, 32'h8000_0000);
        rd(3'd3, v); chk("R2 fall readable at clear addr", v, 32'h8000_0000);
    endtask

    task automatic t_edges();
        logic [31:0] v;
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'h0000_0001);
        wr(3'd2, 32'h0000_0002);
        drive(32'h0000_0001);
        rd(3'd4, v); chk("R3 rise sets bit0", v, 32'h0000_0001);
        drive(32'h0000_0002);
        rd(3'd4, v); chk("R4 fall on bit0 ignored, rise on bit1 ignored", v, 32'h0000_0001);
        drive(32'h0000_0000);
        rd(3'd4, v); chk("R4 fall sets bit1", v, 32'h0000_0003);
        wr(3'd4, 32'h0000_0003);
        wr(3'd0, 32'h0010_0000);
        wr(3'd2, 32'h0010_0000);
        drive(32'h0010_0000);
        rd(3'd4, v); chk("R5 both enables rise", v, 32'h0010_0000);
        wr(3'd4, 32'h0010_0000);
        rd(3'd4, v); chk("R6 w1c clears", v, 32'h0);
        drive(32'h0000_0000);
        rd(3'd4, v); chk("R5 both enables fall", v, 32'h0010_0000);
        drive(32'h0000_0001);
        rd(3'd4, v); chk("R3 rise bit0 again", v, 32'h0010_0001);
        wr(3'd4, 32'h0000_0001);
        rd(3'd4, v); chk("R6 zero bits untouched", v, 32'h0010_0000);
        repeat (4) @(negedge clk);
        rd(3'd4, v); chk("R6 status is sticky", v, 32'h0010_0000);
    endtask

    task automatic t_collision();
        logic [31:0] v;
        // pins currently 0x1; bit0 enabled for rising, bit20 pending
        drive(32'h0000_0000);
        @(negedge clk);
        pins = 32'h0000_0001;
        wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h0010_0001;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        rd(3'd4, v); chk("R7 edge beats clear", v, 32'h0000_0001);
    endtask

    task automatic t_banks();
        logic [31:0] v;
        drive(32'h0010_0001);
        rd(3'd4, v); chk("R8 setup status", v, 32'h0010_0001);
        chk("R8 no irq while banks off", {30'h0, bank_irq}, 32'h0);
        wr(3'd5, 32'h0000_0001);
        #1 chk("R9 bank0 only", {30'h0, bank_irq}, 32'h1);
        wr(3'd5, 32'h0000_001F);
        #1 chk("R8 both lines", {30'h0, bank_irq}, 32'h3);
        rd(3'd5, v); chk("R9 bank enable readback", v, 32'h0000_001F);
        wr(3'd4, 32'h0000_0001);
        #1 chk("R8 line0 drops after clear", {30'h0, bank_irq}, 32'h2);
        wr(3'd4, 32'h0010_0000);
        #1 chk("R8 line1 drops after clear", {30'h0, bank_irq}, 32'h0);
    endtask

    task automatic t_bulk_off();
        logic [31:0] v;
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd3, 32'hFFFF_FFFF);
        rd(3'd0, v); chk("R11 rise mask cleared", v, 32'h0);
        rd(3'd2, v); chk("R11 fall mask cleared", v, 32'h0);
        drive(32'hFFFF_FFFF);
        drive(32'h0000_0000);
        rd(3'd4, v); chk("R11 no events when disabled", v, 32'h0);
        chk("R11 lines low", {30'h0, bank_irq}, 32'h0);
    endtask

    task automatic t_reset_again();
        logic [31:0] v;
        wr(3'd0, 32'h0000_0004);
        wr(3'd2, 32'h0000_0008);
        drive(32'h0000_0004);
        rd(3'd4, v); chk("R3 pre-reset event", v, 32'h0000_0004);
        do_reset();
        t_reset_state();
    endtask

    initial begin
        pins = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        do_reset();
        t_reset_state();
        t_masks();
        t_edges();
        t_collision();
        t_banks();
        t_bulk_off();
        t_reset_again();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule